// File: doc/BRIEF.md
# Fractional Clock Divider with Source Select

This block is a general-purpose clock generator. All clocks are modelled as single-cycle enable pulses in one fast clock domain. One of up to sixteen enable sources is chosen by a source field in a control register. Its pulses are divided by a fixed-point divisor held in a divide register, and the result leaves as an output enable stream. The integer and fractional widths of the divisor are fixed per instance. Both may be zero, and the block then passes the selected source through undivided.

Division uses a phase accumulator. Each selected source pulse adds one unit (2^FRAC_W) to the accumulator. When the sum reaches the divisor, the block emits an output pulse and subtracts the divisor, so the output rate is the input rate times 2^FRAC_W over the divisor. Software writes and reads the two registers through a plain word port. A busy flag in the control register always reads back the same as the enable flag.

Top module: `clkgen_frac_div`

## Requirements
- R1: Address 0 selects the control register: SRC in bits [3:0], ENABLE in bit 4, and a read-only BUSY in bit 7 that always reads equal to ENABLE. Writes to bit 7 and to bits other than [4:0] are ignored. Address 1 selects the divide register: bits [23:0] are stored and bits [31:24] read as 0. `rd_data` shows the register addressed by `rd_addr` one cycle later, and `busy` equals ENABLE.
- R2: After reset both registers read 0 and `tick_out` is 0.
- R3: Source 0 is ground: with SRC = 0, `tick_out` stays 0 whatever `src_en` does.
- R4: While ENABLE is 0, `tick_out` is 0 and the accumulator is cleared to 0.
- R5: The divisor D is DIV[12+INT_W-1 : 12-FRAC_W], an unsigned value in units of 2^-FRAC_W. The fraction field ends at bit 11 and the integer field starts at bit 12. With the defaults (INT_W = 4, FRAC_W = 4), D is DIV[15:8].
- R6: With ENABLE set and D >= 2^FRAC_W, each cycle in which the selected source pulses adds 2^FRAC_W to the accumulator. If the sum is at least D, `tick_out` is 1 in the following cycle and the accumulator keeps the sum minus D. Otherwise the accumulator keeps the sum and `tick_out` is 0.
- R7: A divisor of D = 0 stops the output: `tick_out` stays 0 and the accumulator is held at 0.
- R8: A nonzero divisor below one unit (0 < D < 2^FRAC_W) saturates: every selected pulse gives a `tick_out` pulse in the next cycle, and the accumulator stays 0.
- R9: Pulses on sources that are not selected have no effect on `tick_out` or on the accumulator. The accumulator value is kept across a change of SRC.
- R10: An instance with INT_W = FRAC_W = 0 passes the source through: `tick_out` equals ENABLE and the selected pulse, delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; every source is an enable in this domain |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control, 1 divide |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read target: 0 control, 1 divide |
| rd_data | output | 32 | Registered read data |
| src_en | input | NUM_SRC | Source enable pulses; bit 0 is never used |
| busy | output | 1 | Mirror of ENABLE |
| tick_out | output | 1 | Divided output enable pulse |

## Verification
The bench drives random pulse densities on all sixteen sources and selects divisors on each side of the one-unit boundary. These include a fractional 2.5, exactly 1.0, 0.5 and the largest value the field holds. A design that sends sub-unit divisors down the subtraction path would let its accumulator run away and drop output pulses. A design that resets the accumulator on a source change, or takes the divisor from the wrong bit offset, drifts from the model in tick phase. Ground selection, a zero divisor and disabling are exercised while the other sources are busy, and each must silence the output at once. A passthrough instance checks the zero-width case on the same stimulus.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int SRC_W        = 4;
  localparam int DATA_W       = 32;
  localparam int DIV_STORE_W  = 24;
  localparam int FRAC_TOP     = 12;  // fraction field ends just below this bit
  localparam int CTL_EN_BIT   = 4;
  localparam int CTL_BUSY_BIT = 7;

  typedef enum logic {
    SEL_CTL = 1'b0,
    SEL_DIV = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
  import clkgen_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic [SRC_W-1:0]       src_q,
  output logic                   en_q,
  output logic [DIV_STORE_W-1:0] div_q
);
  logic [DATA_W-1:0] ctl_view;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^wr_data[DATA_W-1:DIV_STORE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      en_q  <= 1'b0;
      div_q <= '0;
    end else if (wr_en) begin
      if (reg_sel_e'(wr_addr) == SEL_DIV) begin
        div_q <= wr_data[DIV_STORE_W-1:0];
      end else begin
        src_q <= wr_data[SRC_W-1:0];
        en_q  <= wr_data[CTL_EN_BIT];
      end
    end
  end

  always_comb begin
    ctl_view               = '0;
    ctl_view[SRC_W-1:0]    = src_q;
    ctl_view[CTL_EN_BIT]   = en_q;
    ctl_view[CTL_BUSY_BIT] = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (reg_sel_e'(rd_addr) == SEL_DIV) begin
      rd_data <= {{(DATA_W-DIV_STORE_W){1'b0}}, div_q};
    end else begin
      rd_data <= ctl_view;
    end
  end
endmodule

// File: rtl/clkgen_src_sel.sv
module clkgen_src_sel
  import clkgen_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [SRC_W-1:0]   src_q,
  output logic               sel_pulse
);
  localparam int SPAN = 1 << SRC_W;
  logic [SPAN-1:0] gated;

  genvar gi;
  generate
    for (gi = 0; gi < SPAN; gi++) begin : g_src
      if (gi == 0 || gi >= NUM_SRC) begin : g_gnd
        assign gated[gi] = 1'b0;
      end else begin : g_live
        assign gated[gi] = src_en[gi];
      end
    end
  endgenerate

  logic unused_src0;
  assign unused_src0 = src_en[0];
  assign sel_pulse   = gated[src_q];
endmodule

// File: rtl/clkgen_phase_acc.sv
module clkgen_phase_acc
  import clkgen_pkg::*;
#(
  parameter int INT_W  = 4,
  parameter int FRAC_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   enable,
  input  logic [DIV_STORE_W-1:0] div_word,
  input  logic                   pulse_in,
  output logic                   tick_out
);
  localparam int TOT = INT_W + FRAC_W;
  localparam int DW  = (TOT == 0) ? 1 : TOT;
  localparam int AW  = DW + 1;
  localparam int LO  = FRAC_TOP - FRAC_W;

  logic unused_div_bits;
  assign unused_div_bits = ^div_word;

  generate
    if (TOT == 0) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) tick_out <= 1'b0;
        else     tick_out <= enable & pulse_in;
      end

      a_r10_passthrough: assert property (@(posedge clk) disable iff (rst)
        (enable && pulse_in) |=> tick_out);
    end else begin : g_acc
      localparam logic [AW-1:0] ONE = AW'(1) << FRAC_W;
      logic [DW-1:0] divisor;
      logic [AW-1:0] dv_ext, acc, sum;
      logic          sub_unit;

      assign divisor  = div_word[LO +: DW];
      assign dv_ext   = {1'b0, divisor};
      assign sum      = acc + ONE;
      assign sub_unit = dv_ext < ONE;

      always_ff @(posedge clk) begin
        if (rst || !enable || divisor == '0) begin
          acc      <= '0;
          tick_out <= 1'b0;
        end else if (sub_unit) begin
          acc      <= '0;
          tick_out <= pulse_in;
        end else if (pulse_in) begin
          if (sum >= dv_ext) begin
            acc      <= sum - dv_ext;
            tick_out <= 1'b1;
          end else begin
            acc      <= sum;
            tick_out <= 1'b0;
          end
        end else begin
          tick_out <= 1'b0;
        end
      end

      a_r7_zero_div_stops: assert property (@(posedge clk) disable iff (rst)
        (divisor == '0) |=> !tick_out);
      a_r8_sub_unit_saturates: assert property (@(posedge clk) disable iff (rst)
        (enable && divisor != '0 && sub_unit && pulse_in) |=> tick_out);
      a_r6_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick_out && $stable(divisor) && dv_ext >= (ONE << 1)) |=> !tick_out);
    end
  endgenerate

  a_r9_tick_needs_pulse: assert property (@(posedge clk) disable iff (rst)
    tick_out |-> $past(pulse_in && enable));
endmodule

// File: rtl/clkgen_frac_div.sv
module clkgen_frac_div
  import clkgen_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int INT_W   = 4,
  parameter int FRAC_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [31:0]        wr_data,
  input  logic               rd_addr,
  output logic [31:0]        rd_data,
  input  logic [NUM_SRC-1:0] src_en,
  output logic               busy,
  output logic               tick_out
);
  logic [SRC_W-1:0]       src_q;
  logic                   en_q;
  logic [DIV_STORE_W-1:0] div_q;
  logic                   sel_pulse;

  clkgen_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .src_q(src_q), .en_q(en_q), .div_q(div_q)
  );

  clkgen_src_sel #(.NUM_SRC(NUM_SRC)) u_sel (
    .src_en(src_en), .src_q(src_q), .sel_pulse(sel_pulse)
  );

  clkgen_phase_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst(rst), .enable(en_q), .div_word(div_q),
    .pulse_in(sel_pulse), .tick_out(tick_out)
  );

  assign busy = en_q;

  a_r4_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !tick_out);
  a_r3_ground_silent: assert property (@(posedge clk) disable iff (rst)
    (src_q == '0) |=> !tick_out);
endmodule

// File: tb/clkgen_frac_div_tb_top.sv
module clkgen_frac_div_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 16;
  localparam int IW = 4;
  localparam int FW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [NSRC-1:0] src_en = '0;
  logic [31:0] rd_data, rd_pt;
  logic busy, tick, busy_pt, tick_pt;

  int checks = 0, fails = 0, cyc = 0;
  int density = 50;
  bit checking = 0;
  string cur_req = "R6";

  // reference model state
  int m_src = 0, m_acc = 0;
  bit m_en = 0;
  logic [23:0] m_div = '0;
  bit exp_tick = 0, exp_pt = 0;
  logic [31:0] exp_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkgen_frac_div #(.NUM_SRC(NSRC), .INT_W(IW), .FRAC_W(FW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .src_en(src_en),
    .busy(busy), .tick_out(tick)
  );

  clkgen_frac_div #(.NUM_SRC(NSRC), .INT_W(0), .FRAC_W(0)) dut_pt_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_pt), .src_en(src_en),
    .busy(busy_pt), .tick_out(tick_pt)
  );

  always @(posedge clk) begin
    int d;
    bit p;
    if (rst) begin
      m_src = 0; m_en = 0; m_div = '0; m_acc = 0;
      exp_tick = 0; exp_pt = 0; exp_rd = '0;
    end else begin
      p = (m_src != 0) && src_en[m_src];
      exp_pt = m_en && p;
      d = int'((m_div >> (12 - FW)) & ((1 << (IW + FW)) - 1));
      if (!m_en || d == 0) begin
        m_acc = 0; exp_tick = 0;
      end else if (d < (1 << FW)) begin
        m_acc = 0; exp_tick = p;
      end else if (p) begin
        if (m_acc + (1 << FW) >= d) begin
          m_acc = m_acc + (1 << FW) - d; exp_tick = 1;
        end else begin
          m_acc = m_acc + (1 << FW); exp_tick = 0;
        end
      end else begin
        exp_tick = 0;
      end
      exp_rd = rd_addr ? {8'h00, m_div}
                       : {24'h0, m_en, 2'b00, m_en, m_src[3:0]};
      if (wr_en) begin
        if (wr_addr) m_div = wr_data[23:0];
        else begin m_src = int'(wr_data[3:0]); m_en = wr_data[4]; end
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && checking) begin
      check(cur_req, {31'b0, tick}, {31'b0, exp_tick});
      check("R10", {31'b0, tick_pt}, {31'b0, exp_pt});
      check("R1", {31'b0, busy}, {31'b0, m_en});
      check("R1", rd_data, exp_rd);
    end
  end

  always @(negedge clk) begin
    for (int i = 0; i < NSRC; i++) src_en[i] <= (($urandom % 100) < density);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic wr(bit a, logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    run(3);
    // R2: reset state while held in reset
    check("R2", {31'b0, tick}, 32'h0);
    check("R2", rd_data, 32'h0);
    check("R2", {31'b0, busy}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    checking = 1;
    run(2);
    rd_addr = 1'b1; run(2);
    check("R2", rd_data, 32'h0);
    rd_addr = 1'b0;

    cur_req = "R7";           // R7: DIV still zero, enable source 1
    wr(1'b0, 32'h11);
    run(100);

    cur_req = "R5";           // R5/R6: divisor 2.5 at DIV[15:8]
    wr(1'b1, 32'h0000_2800);
    run(300);
    cur_req = "R6";           // R6: 1.5 and 1.0 on a sparse source
    density = 30;
    wr(1'b1, 32'h0000_1800);
    run(300);
    wr(1'b1, 32'h0000_1000);
    run(200);

    cur_req = "R8";           // R8: 0.5 saturates
    density = 50;
    wr(1'b1, 32'h0000_0800);
    run(200);

    cur_req = "R9";           // R9: retarget to source 9 with acc mid-way
    wr(1'b1, 32'h0000_7300);
    run(57);
    wr(1'b0, 32'h19);
    density = 70;
    run(300);

    cur_req = "R3";           // R3: ground while others pulse
    wr(1'b0, 32'h10);
    run(150);

    cur_req = "R4";           // R4: disabled, BUSY write ignored
    wr(1'b0, 32'hFFFF_FF85);
    rd_addr = 1'b0; run(2);
    check("R1", rd_data, 32'h0000_0005);
    run(150);
    wr(1'b0, 32'h15);
    run(200);

    cur_req = "R5";           // R5: all ones; upper bits dropped
    wr(1'b1, 32'hFFFF_FFFF);
    rd_addr = 1'b1; run(2);
    check("R1", rd_data, 32'h00FF_FFFF);
    density = 90;
    run(600);

    cur_req = "R7";           // R7: zero divisor with other bits set
    wr(1'b1, 32'hFF00_00FF);
    run(150);

    checking = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule